// File: doc/BRIEF.md
# Counter-Sequenced Byte Serializer Controller

This controller paces the transfer of bytes from a byte queue into a parallel-load shift register and from there, one bit at a time, onto a serial link. The link raises a ready input in each cycle it accepts a bit. The controller answers with three strobes. Shift moves the register by one place. Load copies the queue head into the register. Pop retires the queue head. The queue, the shift register and the link are outside the block. Bits leave most significant bit first.

The sequencing state is a small binary counter, not a hand-encoded state table. Codes 0 up to DATA_W-1 give the index of the bit on the line. One extra all-ones code is a wait state for bit 0. A decoder turns the count and the ready input into one counter command: hold, step, clear or jump. Holding gives the self-loop while the link stalls. Clearing at the last bit returns to the top. Jumping enters and leaves the bit-0 wait state, so the pop issued at bit 0 is never repeated during a stall.

Init is a synchronous restart. It loads the first byte and parks the counter at bit 0.

Top module: `serctl_top`

## Requirements
- R1: While init is high, load is high and pop and shift are low in every cycle.
- R2: In the first cycle after init falls, pop is high.
- R3: Outside init, shift equals ready in every cycle, including stalls at the first bit.
- R4: Outside init, load is high exactly in the cycle that carries the DATA_W-th shift since the previous load, and that cycle also carries a shift.
- R5: In the cycle after any load (init excluded), pop is high.
- R6: The serial stream matches the queued bytes in order, MSB first, under any ready pattern, with no bit lost or repeated. The stream is the shift register's MSB, taken in each shift cycle. The register loads the queue head on load, and pop retires the head. While ready is low, the bit position is held.
- R7: Pop is never high in two consecutive cycles. A stall in the bit-0 cycle does not repeat the pop.
- R8: Outside init, load is never high while ready is low. A stall on the last bit delays the load until ready returns.
- R9: An init in the middle of a byte abandons that byte. The byte at the queue head is then sent complete from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| init | input | 1 | Synchronous restart; loads the first byte |
| rdy | input | 1 | Link accepts the bit on the line this cycle |
| pop | output | 1 | Retire the queue head |
| load | output | 1 | Copy the queue head into the shift register |
| shift | output | 1 | Advance the shift register by one bit |

## Verification
Every cycle, the assertions check the strobe relations: a load only on the DATA_W-th shift, a pop right after each load and never twice in a row, and shift following ready. They also check that the counter holds its position during a stall and stays within its legal codes. Only the bench scenarios can show that the reassembled serial stream equals the queued bytes. They drive steady, alternating, random and long-stall ready patterns, and they restart in the middle of a byte.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_STEP  = 2'd1,
    CNT_CLEAR = 2'd2,
    CNT_JUMP  = 2'd3
  } cnt_op_e;

  // Counter command from the decoded position and the link ready input.
  function automatic cnt_op_e pick_op(logic at_first, logic at_wait,
                                      logic at_last, logic rdy);
    cnt_op_e op;
    if (at_last && rdy)        op = CNT_CLEAR;  // last bit taken: back to top
    else if (at_first && !rdy) op = CNT_JUMP;   // park bit 0 in wait code
    else if (at_wait && rdy)   op = CNT_JUMP;   // bit 0 taken from wait code
    else if (rdy)              op = CNT_STEP;
    else                       op = CNT_HOLD;   // self-loop on stall
    return op;
  endfunction

endpackage

// File: rtl/serctl_counter.sv
module serctl_counter
  import serctl_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             init,
  input  cnt_op_e          op,
  input  logic [CNT_W-1:0] jump_val,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (init) begin
      cnt_q <= '0;
    end else begin
      case (op)
        CNT_STEP:  cnt_q <= cnt_q + CNT_W'(1);
        CNT_CLEAR: cnt_q <= '0;
        CNT_JUMP:  cnt_q <= jump_val;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/serctl_decode.sv
module serctl_decode
  import serctl_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int LAST_CODE = 7,
  parameter int WAIT_CODE = 15
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             rdy,
  input  logic             init,
  output cnt_op_e          op,
  output logic [CNT_W-1:0] jump_val,
  output logic             pop,
  output logic             load,
  output logic             shift
);

  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST_CODE);
  localparam logic [CNT_W-1:0] WAIT_V = CNT_W'(WAIT_CODE);
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic at_first, at_wait, at_last;

  assign at_first = (cnt == '0);
  assign at_wait  = (cnt == WAIT_V);
  assign at_last  = (cnt == LAST_V);

  always_comb begin
    op       = pick_op(at_first, at_wait, at_last, rdy);
    jump_val = at_first ? WAIT_V : ONE_V;
  end

  assign pop   = at_first & ~init;
  assign load  = init | (at_last & rdy);
  assign shift = rdy & ~init;

endmodule

// File: rtl/serctl_top.sv
module serctl_top
  import serctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic init,
  input  logic rdy,
  output logic pop,
  output logic load,
  output logic shift
);

  // One code per bit plus a distinct all-ones wait code for bit 0.
  localparam int CNT_W     = $clog2(DATA_W) + 1;
  localparam int LAST_CODE = DATA_W - 1;
  localparam int WAIT_CODE = (1 << CNT_W) - 1;

  cnt_op_e          cnt_op;
  logic [CNT_W-1:0] jump_val;
  logic [CNT_W-1:0] cnt_q;

  serctl_decode #(
    .CNT_W    (CNT_W),
    .LAST_CODE(LAST_CODE),
    .WAIT_CODE(WAIT_CODE)
  ) u_dec (
    .cnt     (cnt_q),
    .rdy     (rdy),
    .init    (init),
    .op      (cnt_op),
    .jump_val(jump_val),
    .pop     (pop),
    .load    (load),
    .shift   (shift)
  );

  serctl_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .init    (init),
    .op      (cnt_op),
    .jump_val(jump_val),
    .cnt_q   (cnt_q)
  );

endmodule

// File: rtl/serctl_chk.sv
module serctl_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             init,
  input logic             rdy,
  input logic             pop,
  input logic             load,
  input logic             shift,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] WAIT_V = '1;

  int sh_since_load;

  always_ff @(posedge clk) begin
    if (init || load) sh_since_load <= 0;
    else if (shift)   sh_since_load <= sh_since_load + 1;
  end

  a_r1_init_strobes: assert property (@(posedge clk)
    init |-> (load && !pop && !shift));

  a_r2_pop_after_init: assert property (@(posedge clk)
    $fell(init) |-> pop);

  a_r3_shift_on_rdy: assert property (@(posedge clk) disable iff (init)
    shift == rdy);

  a_r4_full_byte: assert property (@(posedge clk) disable iff (init)
    load |-> (shift && sh_since_load == DATA_W - 1));

  a_r5_pop_follows_load: assert property (@(posedge clk) disable iff (init)
    load |=> pop);

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (init)
    (!rdy && cnt != '0) |=> $stable(cnt));

  a_r6_legal_code: assert property (@(posedge clk) disable iff (init)
    (cnt <= LAST_V) || (cnt == WAIT_V));

  a_r7_single_pop: assert property (@(posedge clk) disable iff (init)
    pop |=> !pop);

  a_r8_load_needs_rdy: assert property (@(posedge clk) disable iff (init)
    load |-> rdy);

endmodule

bind serctl_top serctl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk  (clk),
  .init (init),
  .rdy  (rdy),
  .pop  (pop),
  .load (load),
  .shift(shift),
  .cnt  (cnt_q)
);

// File: tb/serctl_top_test.sv
module serctl_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic clk  = 1'b0;
  logic init = 1'b1;
  logic rdy  = 1'b0;
  logic pop, load, shift;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serctl_top #(.DATA_W(DATA_W)) uut (
    .clk  (clk),
    .init (init),
    .rdy  (rdy),
    .pop  (pop),
    .load (load),
    .shift(shift)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] fifo_q[$];   // queue model feeding the register
  logic [DATA_W-1:0] exp_q[$];    // scoreboard of bytes still owed
  logic [DATA_W-1:0] sr_m   = '0;
  logic [DATA_W-1:0] col    = '0;
  int                col_n  = 0;
  int                bits_m = 0;
  logic              prev_load = 1'b0;
  logic              prev_init = 1'b1;
  logic              prev_pop  = 1'b0;
  string             byte_tag  = "R6";

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver side of the scoreboard.
  task automatic push_byte(logic [DATA_W-1:0] b);
    fifo_q.push_back(b);
    exp_q.push_back(b);
  endtask

  // Monitor side: compare a reassembled byte against the owed sequence.
  task automatic take_byte(logic [DATA_W-1:0] got);
    logic [DATA_W-1:0] want;
    if (exp_q.size() == 0) return;  // padding after the list ran out
    want = exp_q.pop_front();
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s serial byte actual %h expected %h at %0t", byte_tag, got, want, $time);
    end
  endtask

  task automatic step(logic i, logic r);
    logic e_shift, e_load, e_pop;
    string ltag, ptag;
    @(negedge clk);
    init = i;
    rdy  = r;
    #1;
    e_shift = r && !i;
    e_load  = i || (bits_m == DATA_W - 1 && r);
    e_pop   = !i && prev_load;
    if (i) begin
      ltag = "R1"; ptag = "R1";
    end else begin
      ltag = (bits_m == DATA_W - 1 && !r) ? "R8" : "R4";
      ptag = prev_init ? "R2" : (prev_pop ? "R7" : "R5");
    end
    chk(i ? "R1" : "R3", "shift", shift, e_shift);
    chk(ltag, "load", load, e_load);
    chk(ptag, "pop", pop, e_pop);
    // effects of the coming edge on the external models
    if (shift) begin
      col   = {col[DATA_W-2:0], sr_m[DATA_W-1]};
      sr_m  = {sr_m[DATA_W-2:0], 1'b0};
      col_n++;
      if (col_n == DATA_W) begin
        take_byte(col);
        col_n = 0;
      end
    end
    if (load) sr_m = (fifo_q.size() > 0) ? fifo_q[0] : '0;
    if (pop && fifo_q.size() > 0) void'(fifo_q.pop_front());
    if (i) begin
      bits_m = 0;
      col_n  = 0;
    end else if (r) begin
      bits_m = (bits_m == DATA_W - 1) ? 0 : bits_m + 1;
    end
    prev_load = e_load;
    prev_init = i;
    prev_pop  = e_pop;
  endtask

  task automatic restart(int n, int salt);
    fifo_q.delete();
    exp_q.delete();
    for (int k = 0; k < n; k++) push_byte(DATA_W'(k * 37 + salt * 11 + 5) ^ DATA_W'(salt));
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
  endtask

  // mode 0: steady ready, 1: alternate, 2: random, 3: long stalls
  task automatic drain(int mode);
    int c;
    logic r;
    c = 0;
    while (exp_q.size() > 0 && c < 6000) begin
      case (mode)
        0:       r = 1'b1;
        1:       r = c[0];
        2:       r = ($urandom_range(0, 3) != 0);
        default: r = ((c % 23) < 5);
      endcase
      step(1'b0, r);
      c++;
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 bytes left actual %0d expected 0", exp_q.size());
    end
  endtask

  initial begin
    // R1: reset state under init
    restart(6, 1);
    drain(0);            // R3 R4 R5 R6 steady ready
    restart(6, 2);
    drain(1);            // alternating ready
    restart(10, 3);
    drain(2);            // random ready, stalls on first and last bits (R7 R8)
    restart(6, 4);
    drain(3);            // long stalls
    // R9: restart in the middle of a byte
    restart(4, 5);
    for (int k = 0; k < 13; k++) step(1'b0, 1'b1);
    byte_tag = "R9";
    restart(5, 6);
    drain(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule